// File: doc/BRIEF.md
# Fail-first vector length truncator

This block sequences the elements of one vector operation in strict order, one element per clock, and decides for each element whether its result and its condition field may be written back. It also decides whether the vector ends early. A run starts with a `start` pulse. That pulse captures the vector length and the per-operation mode pins. Elements then arrive on a valid/ready stream that carries either an exception flag (memory variant) or a 4-bit condition field (condition variant). The block answers with same-cycle write enables for the accepted element.

When the run stops, the block pulses `done` and presents the final length on `new_vl`. The run stops when an element fails, when element 0 of a memory operation faults, or after the last element. In the memory variant, a fault on element 0 is reported on `trap` so that the normal exception path can handle it, and the length stays as it was. A fault on any later element shortens the vector to the elements before it. In the condition variant, one selected bit of the field is compared with an inverse flag. A match fails the element and drops it and everything after it, and the length may become zero.

Back-pressure: `elem_ready` is high exactly while a run is active. An element is consumed only on a cycle where `elem_valid` and `elem_ready` are both high. While `elem_valid` is low the stream stalls without effect. After the terminating element the block drops `elem_ready`, and the producer must not present further elements of that vector.

Top module: `ffirst_trunc`

## Requirements
- R1: After reset `busy`, `elem_ready`, `done`, `trap`, `res_we` and `cr_we` are 0 and `new_vl` is 0.
- R2: Memory variant (`mode`=0): an element with index i>0 accepted with `elem_exc`=1 writes nothing, and one cycle later `done`=1 with `new_vl`=i.
- R3: Memory variant: `elem_exc`=1 on element 0 writes nothing, and one cycle later gives `done`=1, `trap`=1 and `new_vl` equal to the starting length. This variant never yields a zero length from a nonzero start.
- R4: Condition variant (`mode`=1): an element fails when `elem_cr[bit_sel]` equals `inv`. A failing element writes nothing, and one cycle later `done`=1 with `new_vl`=i when `vli`=0.
- R5: On a condition-variant failure with `vli`=1 and `rc`=0, `new_vl`=i+1. When `rc`=1, `vli` is disregarded and `new_vl`=i.
- R6: A condition-variant failure on element 0 (with `vli`=0) gives `new_vl`=0 and no write enable at any point in the run.
- R7: With `rc1`=1 in the condition variant, passing elements assert `cr_we` and `res_we` stays 0 throughout.
- R8: A passing condition-variant element asserts `res_we` when `rc1`=0, and asserts `cr_we` when `rc` or `rc1` is 1. A non-faulting memory element asserts `res_we` only.
- R9: If no element fails, `done` pulses for one cycle, one cycle after the last element is accepted, with `new_vl` equal to the starting length. The length is never shortened for any other reason.
- R10: Write enables are 0 on any cycle without an accepted element. `elem_idx` advances only on acceptance.
- R11: A `start` with `vl_in`=0 gives `done`=1 with `new_vl`=0 on the next cycle and accepts no element.
- R12: A `start` pulse while `busy`=1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (ignored while busy) |
| vl_in | input | VL_W | Starting vector length |
| mode | input | 1 | 0 = memory fault variant, 1 = condition-bit variant |
| bit_sel | input | SEL_W | Index of the condition bit to test |
| inv | input | 1 | Value of the tested bit that counts as failure |
| vli | input | 1 | Count the failing element into the new length |
| rc | input | 1 | Record condition fields alongside results |
| rc1 | input | 1 | Record condition fields only, never results |
| elem_valid | input | 1 | Element present on the stream |
| elem_ready | output | 1 | Block accepts an element this cycle |
| elem_exc | input | 1 | Element would raise a memory exception |
| elem_cr | input | CR_W | Element condition field |
| res_we | output | 1 | Write the accepted element's result |
| cr_we | output | 1 | Write the accepted element's condition field |
| elem_idx | output | VL_W | Index of the element at the stream head |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse: run finished |
| trap | output | 1 | With done: element 0 faulted, take exception |
| new_vl | output | VL_W | Final vector length, held until next start |

## Verification
The last element of a vector can also be the failing one, so the end-of-vector decision and the truncation decision fall in the same cycle. The bench places the forced failure on index vl-1 in directed runs and, at random, in others. It judges the outcome by whether `new_vl` equals vl-1 (or vl with `vli`) rather than vl, and whether the write enables stay low on that element. A second collision, a `start` pulse that coincides with an element being accepted mid-run, is provoked and judged by an unchanged final length.

// File: rtl/ffirst_pkg.sv
package ffirst_pkg;
  localparam int CR_W  = 4;
  localparam int SEL_W = $clog2(CR_W);

  typedef enum logic {
    FF_MEM  = 1'b0,
    FF_COND = 1'b1
  } ff_mode_e;

  typedef struct packed {
    ff_mode_e           mode;
    logic [SEL_W-1:0]   bsel;
    logic               inv;
    logic               vli;
    logic               rc;
    logic               rc1;
  } ff_cfg_t;
endpackage

// File: rtl/ffirst_judge.sv
module ffirst_judge
  import ffirst_pkg::*;
(
  input  ff_cfg_t         cfg,
  input  logic            first,
  input  logic            exc,
  input  logic [CR_W-1:0] cr,
  output logic            fail,
  output logic            fault0,
  output logic            res_ok,
  output logic            cr_ok
);
  logic tbit;

  assign tbit = cr[cfg.bsel];

  always_comb begin
    fail   = 1'b0;
    fault0 = 1'b0;
    res_ok = 1'b0;
    cr_ok  = 1'b0;
    if (cfg.mode == FF_COND) begin
      fail   = (tbit == cfg.inv);
      res_ok = !fail && !cfg.rc1;
      cr_ok  = !fail && (cfg.rc || cfg.rc1);
    end else begin
      fail   = exc && !first;
      fault0 = exc && first;
      res_ok = !exc;
    end
  end
endmodule

// File: rtl/ffirst_len_ctrl.sv
module ffirst_len_ctrl
  import ffirst_pkg::*;
#(
  parameter int VL_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [VL_W-1:0] vl_in,
  input  ff_cfg_t         cfg_in,
  input  logic            accept,
  input  logic            fail,
  input  logic            fault0,
  output ff_cfg_t         cfg_q,
  output logic            busy,
  output logic [VL_W-1:0] idx,
  output logic            done,
  output logic            trap,
  output logic [VL_W-1:0] new_vl
);
  localparam logic [VL_W-1:0] ONE = VL_W'(1);

  logic [VL_W-1:0] vl_cap;
  logic            last;
  logic            keep_fail;

  assign last      = (idx == vl_cap - ONE);
  assign keep_fail = (cfg_q.mode == FF_COND) && cfg_q.vli && !cfg_q.rc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      idx    <= '0;
      vl_cap <= '0;
      cfg_q  <= '0;
      done   <= 1'b0;
      trap   <= 1'b0;
      new_vl <= '0;
    end else begin
      done <= 1'b0;
      trap <= 1'b0;
      if (!busy) begin
        if (start) begin
          cfg_q  <= cfg_in;
          vl_cap <= vl_in;
          idx    <= '0;
          if (vl_in == '0) begin
            done   <= 1'b1;
            new_vl <= '0;
          end else begin
            busy <= 1'b1;
          end
        end
      end else if (accept) begin
        if (fail) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          new_vl <= keep_fail ? idx + ONE : idx;
        end else if (fault0) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          trap   <= 1'b1;
          new_vl <= vl_cap;
        end else if (last) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          new_vl <= vl_cap;
        end else begin
          idx <= idx + ONE;
        end
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_VL_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    done && (cfg_q.mode == FF_COND) && !keep_fail |-> new_vl < vl_cap || new_vl == vl_cap); // R9
  AST_MEM_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    done && (cfg_q.mode == FF_MEM) && (vl_cap != '0) |-> new_vl != '0); // R3
  AST_TRAP_KEEPS_VL: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> done && new_vl == vl_cap); // R3
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !accept |=> $stable(idx)); // R10
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !accept |=> $stable(vl_cap)); // R12
endmodule

// File: rtl/ffirst_trunc.sv
module ffirst_trunc
  import ffirst_pkg::*;
#(
  parameter int VL_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [VL_W-1:0]  vl_in,
  input  logic             mode,
  input  logic [SEL_W-1:0] bit_sel,
  input  logic             inv,
  input  logic             vli,
  input  logic             rc,
  input  logic             rc1,
  input  logic             elem_valid,
  output logic             elem_ready,
  input  logic             elem_exc,
  input  logic [CR_W-1:0]  elem_cr,
  output logic             res_we,
  output logic             cr_we,
  output logic [VL_W-1:0]  elem_idx,
  output logic             busy,
  output logic             done,
  output logic             trap,
  output logic [VL_W-1:0]  new_vl
);
  ff_cfg_t cfg_in, cfg_q;
  logic    accept, fail, fault0, res_ok, cr_ok;

  assign cfg_in = '{mode: ff_mode_e'(mode), bsel: bit_sel, inv: inv,
                    vli: vli, rc: rc, rc1: rc1};

  assign elem_ready = busy;
  assign accept     = elem_valid && busy;
  assign res_we     = accept && res_ok;
  assign cr_we      = accept && cr_ok;

  ffirst_judge u_judge (
    .cfg    (cfg_q),
    .first  (elem_idx == '0),
    .exc    (elem_exc),
    .cr     (elem_cr),
    .fail   (fail),
    .fault0 (fault0),
    .res_ok (res_ok),
    .cr_ok  (cr_ok)
  );

  ffirst_len_ctrl #(.VL_W(VL_W)) u_len (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .vl_in  (vl_in),
    .cfg_in (cfg_in),
    .accept (accept),
    .fail   (fail),
    .fault0 (fault0),
    .cfg_q  (cfg_q),
    .busy   (busy),
    .idx    (elem_idx),
    .done   (done),
    .trap   (trap),
    .new_vl (new_vl)
  );

  AST_NO_WE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |-> !res_we && !cr_we); // R10
  AST_RC1_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.mode == FF_COND) && cfg_q.rc1 |-> !res_we); // R7
  AST_FAIL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (fail || fault0) |-> !res_we && !cr_we); // R4
  AST_MEM_NO_CR: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.mode == FF_MEM) |-> !cr_we); // R8
endmodule

// File: tb/ffirst_trunc_bench.sv
module ffirst_trunc_bench;
  localparam int VL_W = 7;
  localparam int CR_W = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [VL_W-1:0] vl_in = '0;
  logic            mode = 1'b0;
  logic [1:0]      bit_sel = '0;
  logic            inv = 1'b0, vli = 1'b0, rc = 1'b0, rc1 = 1'b0;
  logic            elem_valid = 1'b0;
  logic            elem_ready;
  logic            elem_exc = 1'b0;
  logic [CR_W-1:0] elem_cr = '0;
  logic            res_we, cr_we, busy, done, trap;
  logic [VL_W-1:0] elem_idx, new_vl;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  ffirst_trunc #(.VL_W(VL_W)) u_ffirst_trunc (
    .clk(clk), .rst_n(rst_n), .start(start), .vl_in(vl_in), .mode(mode),
    .bit_sel(bit_sel), .inv(inv), .vli(vli), .rc(rc), .rc1(rc1),
    .elem_valid(elem_valid), .elem_ready(elem_ready), .elem_exc(elem_exc),
    .elem_cr(elem_cr), .res_we(res_we), .cr_we(cr_we), .elem_idx(elem_idx),
    .busy(busy), .done(done), .trap(trap), .new_vl(new_vl)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected length after a failure at index i (R4, R5, R2)
  function automatic int exp_len_fail(input bit m, input int i, input bit v, input bit r);
    if (m && v && !r) return i + 1;
    return i;
  endfunction

  // Condition field whose selected bit matches (fail) or differs from inv
  function automatic logic [CR_W-1:0] make_cr(input int sel, input bit iv, input bit mk_fail);
    logic [CR_W-1:0] c;
    c = CR_W'($urandom);
    c[sel] = mk_fail ? iv : ~iv;
    return c;
  endfunction

  task automatic run_vec(input bit m, input int vl, input int sel, input bit iv,
                         input bit v, input bit r, input bit r1,
                         input int fail_at, input bit poke);
    bit ended = 0;
    bit exp_trap = 0;
    int exp_vl = vl;
    int i = 0;
    @(negedge clk);
    start = 1; vl_in = VL_W'(vl); mode = m; bit_sel = 2'(sel);
    inv = iv; vli = v; rc = r; rc1 = r1;
    @(posedge clk);
    @(negedge clk);
    start = 0; vl_in = VL_W'($urandom);
    if (vl == 0) begin
      chk(done && new_vl == 0 && !elem_ready, "R11", new_vl, 0);
      return;
    end
    while (!ended) begin
      if ($urandom_range(3) == 0) begin
        elem_valid = 0; elem_cr = CR_W'($urandom); elem_exc = 1'($urandom);
        #1;
        chk(!res_we && !cr_we && elem_idx == VL_W'(i), "R10", elem_idx, i);
        @(posedge clk); @(negedge clk);
      end
      elem_valid = 1;
      if (m) begin elem_cr = make_cr(sel, iv, i == fail_at); elem_exc = 1'($urandom); end
      else begin elem_exc = (i == fail_at); elem_cr = CR_W'($urandom); end
      if (poke && i == 1) begin start = 1; vl_in = 3; end
      #1;
      chk(elem_ready && elem_idx == VL_W'(i), "R10", elem_idx, i);
      if (i == fail_at) begin
        chk(!res_we && !cr_we, m ? "R4" : "R2", {res_we, cr_we}, 0);
        ended = 1;
        if (!m && i == 0) exp_trap = 1;
        else exp_vl = exp_len_fail(m, i, v, r);
      end else begin
        bit e_res, e_cr;
        e_res = m ? !r1 : 1'b1;
        e_cr  = m ? (r || r1) : 1'b0;
        chk(res_we == e_res, r1 ? "R7" : "R8", res_we, e_res);
        chk(cr_we == e_cr, "R8", cr_we, e_cr);
        if (i == vl - 1) ended = 1;
      end
      @(posedge clk); @(negedge clk);
      elem_valid = 0; start = 0;
      i++;
    end
    chk(done && !busy, "R9", done, 1);
    chk(new_vl == VL_W'(exp_vl), poke ? "R12" : (m ? "R4" : "R2"), new_vl, exp_vl);
    chk(trap == exp_trap, "R3", trap, exp_trap);
    @(negedge clk);
    chk(!done && !trap, "R9", done, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!busy && !elem_ready && !done && !trap && !res_we && !cr_we && new_vl == 0,
        "R1", new_vl, 0);
    rst_n = 1;
    // directed corners
    run_vec(1, 5, 2, 1, 0, 0, 0, -1, 0);   // R9 no failure
    run_vec(1, 5, 1, 0, 0, 1, 0, 2, 0);    // R4
    run_vec(1, 5, 0, 1, 1, 0, 0, 3, 0);    // R5 vli counts failing element
    run_vec(1, 5, 0, 1, 1, 1, 0, 3, 0);    // R5 vli disregarded with rc
    run_vec(1, 4, 3, 0, 0, 0, 0, 0, 0);    // R6 zero length
    run_vec(1, 4, 3, 1, 0, 1, 1, 2, 0);    // R7 cr only
    run_vec(1, 6, 1, 1, 0, 0, 0, 5, 0);    // fail on last element
    run_vec(1, 6, 1, 1, 1, 0, 0, 5, 0);    // last element with vli
    run_vec(0, 4, 0, 0, 0, 0, 0, 0, 0);    // R3 element-0 fault
    run_vec(0, 1, 0, 0, 0, 0, 0, 0, 0);    // R3 single element
    run_vec(0, 6, 0, 0, 0, 0, 0, 3, 0);    // R2
    run_vec(0, 6, 0, 0, 0, 0, 0, 5, 0);    // R2 at last element
    run_vec(0, 3, 0, 0, 0, 0, 0, -1, 0);   // R9 memory clean
    run_vec(1, 0, 0, 0, 0, 0, 0, -1, 0);   // R11
    run_vec(1, 6, 2, 0, 0, 0, 0, -1, 1);   // R12 start while busy
    run_vec(0, 6, 2, 0, 0, 0, 0, 4, 1);    // R12 memory
    for (int k = 0; k < 400; k++) begin
      int vl, fa;
      vl = $urandom_range(12);
      fa = (vl == 0) ? -1 : int'($urandom_range(vl + 2)) - 1;
      if (fa >= vl) fa = -1;
      run_vec(1'($urandom), vl, $urandom_range(3), 1'($urandom), 1'($urandom),
              1'($urandom), 1'($urandom), fa, 1'($urandom));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule